// File: doc/BRIEF.md
# Fully Associative Branch Target Buffer

This block sits beside the fetch stage. It gives the next fetch address in the same cycle that a PC is presented. Every slot holds a full branch address as its tag and the address that branch last jumped to. The slot only exists while the branch is believed taken. The lookup compares the presented PC against all tags in parallel. On an exact match, the stored jump address is offered as the next PC. Otherwise the next PC is the sequential address.

A second port reports a branch outcome once execute has resolved it. The block searches its table for the branch address and decides whether the path that fetch followed was wrong. It returns a wrong-path flag and the corrected fetch address. It also changes the table:
- A taken branch that was not found gets a slot.
- A found branch that fell through loses its slot.
- A found branch that jumped somewhere else has its jump address rewritten.

All table changes become visible one cycle after the report. A new slot goes to the lowest-numbered empty slot. When no slot is empty, a round-robin pointer picks the slot to overwrite.

Top module: `btb_assoc`

## Requirements
- R1: After reset every slot is empty, so every lookup misses and no report finds a match.
- R2: A lookup hits only when all PC_W bits of the presented PC equal a stored tag. An address that differs in any single bit, including the most significant one, misses.
- R3: On a hit with `lk_valid` high, `lk_hit` is 1 and `lk_next_pc` is the stored jump address of the matching slot.
- R4: When there is no hit, `lk_hit` is 0 and `lk_next_pc` equals `lk_pc` + 4 (STEP = 4).
- R5: A taken report whose address is not in the table raises `rs_mispredict`, drives `rs_fix_pc` to `rs_target`, and stores the address and target in a slot.
- R6: A not-taken report whose address is in the table raises `rs_mispredict`, drives `rs_fix_pc` to `rs_pc` + 4, and empties that slot.
- R7: A taken report whose address is in the table with a different stored target raises `rs_mispredict`, drives `rs_fix_pc` to `rs_target`, and replaces the stored target.
- R8: Two kinds of report leave `rs_mispredict` low and the table unchanged as seen through later lookups. The first is a taken report that matches with the same target. The second is a not-taken report that does not match.
- R9: A new slot is filled in this order:
  - the lowest-numbered empty slot if any slot is empty;
  - otherwise the slot under a round-robin pointer. The pointer starts at slot 0 after reset and moves forward by one after each overwrite of a full table.
- R10: A report changes the table at the next clock edge. A lookup in the same cycle as the report sees the contents from before the report.
- R11: With `lk_valid` low, `lk_hit` is 0 whatever the table holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Fetch lookup request |
| lk_pc | input | PC_W | PC being fetched |
| lk_hit | output | 1 | Stored jump address is being used |
| lk_next_pc | output | PC_W | Predicted next fetch address |
| rs_valid | input | 1 | A resolved branch is reported |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_taken | input | 1 | Resolved direction, 1 = taken |
| rs_target | input | PC_W | Resolved jump address |
| rs_mispredict | output | 1 | Fetch followed the wrong path |
| rs_fix_pc | output | PC_W | Address fetch should restart from |

## Verification
A lookup and a report can arrive in the same cycle for the same branch address. There are two cases: an insert of a newly taken branch, and a removal of a found branch that fell through. The bench drives both ports together in one cycle. It checks that the lookup still gives the old answer: a miss before the insert, and a hit with the old target before the removal. In the next cycle the bench repeats the lookup alone and checks that the new answer appears.

// File: rtl/btb_pkg.sv
package btb_pkg;

   // Table action chosen by the resolve decoder.
   typedef enum logic [2:0] {
      ACT_NONE     = 3'd0,
      ACT_INSERT   = 3'd1,
      ACT_DROP     = 3'd2,
      ACT_RETARGET = 3'd3,
      ACT_CONFIRM  = 3'd4
   } btb_act_e;

   // Saturated confidence level of a freshly written slot.
   localparam logic [1:0] CONF_FULL = 2'b11;

endpackage

// File: rtl/btb_cam.sv
// Parallel tag compare over all slots; one-hot match plus encoded index.
module btb_cam #(
   parameter int N  = 16,
   parameter int W  = 32,
   parameter int IW = 4
) (
   input  logic [N-1:0]   valid_i,
   input  logic [N*W-1:0] tags_i,
   input  logic [W-1:0]   key_i,
   output logic [N-1:0]   match_o,
   output logic           any_o,
   output logic [IW-1:0]  idx_o
);

   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign match_o[g] = valid_i[g] && (tags_i[g*W +: W] == key_i);
   end

   assign any_o = |match_o;

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (match_o[i]) idx_o = idx_o | IW'(i);
      end
   end

endmodule

// File: rtl/btb_victim.sv
// Picks the slot for a new entry: lowest empty slot, else round-robin.
module btb_victim #(
   parameter int N  = 16,
   parameter int IW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  valid_i,
   input  logic          alloc_i,
   output logic [IW-1:0] slot_o
);

   localparam logic [IW-1:0] LAST = IW'(N - 1);

   logic [IW-1:0] rr_q;
   logic [IW-1:0] free_idx;
   logic          full;

   assign full = &valid_i;

   always_comb begin
      free_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!valid_i[i]) free_idx = IW'(i);
      end
   end

   assign slot_o = full ? rr_q : free_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rr_q <= '0;
      end else if (alloc_i && full) begin
         rr_q <= (rr_q == LAST) ? '0 : rr_q + IW'(1);
      end
   end

endmodule

// File: rtl/btb_table.sv
// Slot storage: valid bit, tag, jump address and optional confidence per slot.
module btb_table
   import btb_pkg::*;
#(
   parameter int N      = 16,
   parameter int W      = 32,
   parameter int IW     = 4,
   parameter bit CTR_EN = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  btb_act_e       act_i,
   input  logic [IW-1:0]  slot_i,
   input  logic [W-1:0]   pc_i,
   input  logic [W-1:0]   tgt_i,
   output logic [N-1:0]   valid_o,
   output logic [N*W-1:0] tags_o,
   output logic [N*W-1:0] tgts_o
);

   logic [N-1:0] keep_w;   // slot survives one fall-through

   for (genvar g = 0; g < N; g++) begin : g_slot
      logic          sel;
      logic          vld_q;
      logic [W-1:0]  tag_q;
      logic [W-1:0]  tgt_q;

      assign sel = (slot_i == IW'(g));

      if (CTR_EN) begin : g_conf
         logic [1:0] conf_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               conf_q <= '0;
            end else if (sel) begin
               case (act_i)
                  ACT_INSERT, ACT_RETARGET, ACT_CONFIRM: conf_q <= CONF_FULL;
                  ACT_DROP:                              conf_q <= conf_q - 2'd1;
                  default:                               conf_q <= conf_q;
               endcase
            end
         end
         assign keep_w[g] = (conf_q == CONF_FULL);
      end else begin : g_noconf
         assign keep_w[g] = 1'b0;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            tag_q <= '0;
            tgt_q <= '0;
         end else if (sel) begin
            case (act_i)
               ACT_INSERT: begin
                  vld_q <= 1'b1;
                  tag_q <= pc_i;
                  tgt_q <= tgt_i;
               end
               ACT_RETARGET: tgt_q <= tgt_i;
               ACT_DROP:     vld_q <= keep_w[g];
               default:      ;
            endcase
         end
      end

      assign valid_o[g]       = vld_q;
      assign tags_o[g*W +: W] = tag_q;
      assign tgts_o[g*W +: W] = tgt_q;
   end

endmodule

// File: rtl/btb_assoc.sv
// Fully associative branch target buffer: fetch lookup and resolve update.
module btb_assoc
   import btb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int PC_W    = 32,
   parameter int STEP    = 4,
   parameter bit CTR_EN  = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lk_valid,
   input  logic [PC_W-1:0] lk_pc,
   output logic            lk_hit,
   output logic [PC_W-1:0] lk_next_pc,
   input  logic            rs_valid,
   input  logic [PC_W-1:0] rs_pc,
   input  logic            rs_taken,
   input  logic [PC_W-1:0] rs_target,
   output logic            rs_mispredict,
   output logic [PC_W-1:0] rs_fix_pc
);

   localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam logic [PC_W-1:0] INC = PC_W'(STEP);

   if (ENTRIES < 2)   begin : g_bad_entries $error("ENTRIES must be at least 2"); end
   if (PC_W < 8)      begin : g_bad_width   $error("PC_W must be at least 8"); end
   if (STEP < 1)      begin : g_bad_step    $error("STEP must be positive"); end

   logic [ENTRIES-1:0]      ent_valid;
   logic [ENTRIES*PC_W-1:0] ent_tags;
   logic [ENTRIES*PC_W-1:0] ent_tgts;

   // Fetch-side search
   logic [ENTRIES-1:0] lk_match;
   logic               lk_any;
   logic [IW-1:0]      lk_idx;
   logic [PC_W-1:0]    lk_tgt;

   btb_cam #(.N(ENTRIES), .W(PC_W), .IW(IW)) u_lk_cam (
      .valid_i (ent_valid),
      .tags_i  (ent_tags),
      .key_i   (lk_pc),
      .match_o (lk_match),
      .any_o   (lk_any),
      .idx_o   (lk_idx)
   );

   assign lk_tgt     = ent_tgts[lk_idx*PC_W +: PC_W];
   assign lk_hit     = lk_valid && lk_any;
   assign lk_next_pc = lk_hit ? lk_tgt : lk_pc + INC;

   // Resolve-side search
   logic [ENTRIES-1:0] rs_match;
   logic               rs_any;
   logic [IW-1:0]      rs_idx;
   logic [PC_W-1:0]    rs_stored;

   btb_cam #(.N(ENTRIES), .W(PC_W), .IW(IW)) u_rs_cam (
      .valid_i (ent_valid),
      .tags_i  (ent_tags),
      .key_i   (rs_pc),
      .match_o (rs_match),
      .any_o   (rs_any),
      .idx_o   (rs_idx)
   );

   assign rs_stored = ent_tgts[rs_idx*PC_W +: PC_W];

   // Resolve decode
   btb_act_e act;
   always_comb begin
      act           = ACT_NONE;
      rs_mispredict = 1'b0;
      if (rs_valid) begin
         if (rs_any) begin
            if (!rs_taken) begin
               act           = ACT_DROP;
               rs_mispredict = 1'b1;
            end else if (rs_stored != rs_target) begin
               act           = ACT_RETARGET;
               rs_mispredict = 1'b1;
            end else begin
               act = ACT_CONFIRM;
            end
         end else if (rs_taken) begin
            act           = ACT_INSERT;
            rs_mispredict = 1'b1;
         end
      end
   end

   assign rs_fix_pc = rs_taken ? rs_target : rs_pc + INC;

   // Slot choice
   logic [IW-1:0] victim;
   logic [IW-1:0] wr_slot;
   logic          alloc;

   assign alloc = (act == ACT_INSERT);

   btb_victim #(.N(ENTRIES), .IW(IW)) u_victim (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (ent_valid),
      .alloc_i (alloc),
      .slot_o  (victim)
   );

   assign wr_slot = alloc ? victim : rs_idx;

   btb_table #(.N(ENTRIES), .W(PC_W), .IW(IW), .CTR_EN(CTR_EN)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .act_i   (act),
      .slot_i  (wr_slot),
      .pc_i    (rs_pc),
      .tgt_i   (rs_target),
      .valid_o (ent_valid),
      .tags_o  (ent_tags),
      .tgts_o  (ent_tgts)
   );

endmodule

// File: rtl/btb_assoc_chk.sv
module btb_assoc_chk #(
   parameter int ENTRIES = 16,
   parameter int PC_W    = 32,
   parameter int STEP    = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic [PC_W-1:0]    lk_pc,
   input logic               lk_hit,
   input logic [PC_W-1:0]    lk_next_pc,
   input logic               rs_valid,
   input logic [PC_W-1:0]    rs_pc,
   input logic               rs_taken,
   input logic [PC_W-1:0]    rs_target,
   input logic               rs_mispredict,
   input logic [PC_W-1:0]    rs_fix_pc,
   input logic [ENTRIES-1:0] vec
);

   // R4
   seq_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> lk_next_pc == lk_pc + PC_W'(STEP));

   // R11
   idle_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> !lk_hit);

   // R6
   fall_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid && !rs_taken) |-> rs_fix_pc == rs_pc + PC_W'(STEP));

   // R5
   taken_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid && rs_taken) |-> rs_fix_pc == rs_target);

   // R8
   quiet_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid && !rs_taken && !rs_mispredict) |=> $stable(vec));

   // R10
   one_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rs_valid |=> $stable(vec));

   // R6
   drop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid && !rs_taken && rs_mispredict) |=> $countones(vec) <= $past($countones(vec)));

endmodule

bind btb_assoc btb_assoc_chk #(.ENTRIES(ENTRIES), .PC_W(PC_W), .STEP(STEP)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .lk_valid      (lk_valid),
   .lk_pc         (lk_pc),
   .lk_hit        (lk_hit),
   .lk_next_pc    (lk_next_pc),
   .rs_valid      (rs_valid),
   .rs_pc         (rs_pc),
   .rs_taken      (rs_taken),
   .rs_target     (rs_target),
   .rs_mispredict (rs_mispredict),
   .rs_fix_pc     (rs_fix_pc),
   .vec           (ent_valid)
);

// File: tb/sim_btb_assoc.sv
`timescale 1ns/1ps
module sim_btb_assoc;

   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        lk_hit;
   logic [31:0] lk_next_pc;
   logic        rs_valid = 1'b0;
   logic [31:0] rs_pc = '0;
   logic        rs_taken = 1'b0;
   logic [31:0] rs_target = '0;
   logic        rs_mispredict;
   logic [31:0] rs_fix_pc;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   btb_assoc u0 (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_next_pc(lk_next_pc),
      .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken), .rs_target(rs_target),
      .rs_mispredict(rs_mispredict), .rs_fix_pc(rs_fix_pc)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive one cycle at the falling edge; outputs settle 2 ns later.
   task automatic cyc(input logic lv, input logic [31:0] lp,
                      input logic rv, input logic [31:0] rp,
                      input logic rt, input logic [31:0] rg);
      @(negedge clk);
      lk_valid = lv; lk_pc = lp;
      rs_valid = rv; rs_pc = rp; rs_taken = rt; rs_target = rg;
      #2;
   endtask

   task automatic look(input string req, input logic [31:0] pc,
                       input logic eh, input logic [31:0] en);
      cyc(1'b1, pc, 1'b0, '0, 1'b0, '0);
      chk(req, {31'd0, lk_hit}, {31'd0, eh});
      chk(req, lk_next_pc, en);
   endtask

   task automatic report(input string req, input logic [31:0] pc, input logic tk,
                         input logic [31:0] tg, input logic emp);
      cyc(1'b0, '0, 1'b1, pc, tk, tg);
      chk(req, {31'd0, rs_mispredict}, {31'd0, emp});
      chk(req, rs_fix_pc, tk ? tg : pc + 32'd4);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      lk_valid = 1'b0; rs_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic logic [31:0] aa(input int i); return 32'h1000_0000 + 32'(i) * 32'd16; endfunction
   function automatic logic [31:0] tt(input int i); return 32'h2000_0000 + 32'(i) * 32'd8;  endfunction

   task automatic t_reset();
      do_reset();
      look("R1", 32'h0000_0000, 1'b0, 32'h0000_0004);
      look("R4", 32'h8000_1230, 1'b0, 32'h8000_1234);
      report("R1", 32'h0000_0040, 1'b0, 32'h0, 1'b0);
   endtask

   task automatic t_insert();
      do_reset();
      // R10: lookup alongside the insert sees the empty table
      cyc(1'b1, 32'h0000_4000, 1'b1, 32'h0000_4000, 1'b1, 32'h0000_9000);
      chk("R10", {31'd0, lk_hit}, 32'd0);
      chk("R10", lk_next_pc, 32'h0000_4004);
      chk("R5", {31'd0, rs_mispredict}, 32'd1);
      chk("R5", rs_fix_pc, 32'h0000_9000);
      look("R3", 32'h0000_4000, 1'b1, 32'h0000_9000);
      report("R8", 32'h0000_5000, 1'b0, 32'h0000_7777, 1'b0);
      look("R8", 32'h0000_5000, 1'b0, 32'h0000_5004);
      look("R2", 32'h8000_4000, 1'b0, 32'h8000_4004);
      look("R2", 32'h0000_4004, 1'b0, 32'h0000_4008);
      look("R2", 32'h0000_4001, 1'b0, 32'h0000_4005);
      // R7 retarget
      report("R7", 32'h0000_4000, 1'b1, 32'h0000_A000, 1'b1);
      look("R7", 32'h0000_4000, 1'b1, 32'h0000_A000);
      report("R8", 32'h0000_4000, 1'b1, 32'h0000_A000, 1'b0);
      look("R8", 32'h0000_4000, 1'b1, 32'h0000_A000);
      // R11
      cyc(1'b0, 32'h0000_4000, 1'b0, '0, 1'b0, '0);
      chk("R11", {31'd0, lk_hit}, 32'd0);
      // R6 + R10: removal in same cycle as lookup
      cyc(1'b1, 32'h0000_4000, 1'b1, 32'h0000_4000, 1'b0, 32'h0);
      chk("R10", {31'd0, lk_hit}, 32'd1);
      chk("R10", lk_next_pc, 32'h0000_A000);
      chk("R6", {31'd0, rs_mispredict}, 32'd1);
      chk("R6", rs_fix_pc, 32'h0000_4004);
      look("R6", 32'h0000_4000, 1'b0, 32'h0000_4004);
   endtask

   task automatic t_fill();
      do_reset();
      for (int i = 0; i < N; i++) report("R5", aa(i), 1'b1, tt(i), 1'b1);
      for (int i = 0; i < N; i++) look("R9", aa(i), 1'b1, tt(i));
      report("R9", aa(16), 1'b1, tt(16), 1'b1);   // overwrites slot 0
      look("R9", aa(0), 1'b0, aa(0) + 32'd4);
      look("R9", aa(1), 1'b1, tt(1));
      look("R9", aa(16), 1'b1, tt(16));
      report("R9", aa(17), 1'b1, tt(17), 1'b1);   // overwrites slot 1
      look("R9", aa(1), 1'b0, aa(1) + 32'd4);
      look("R9", aa(2), 1'b1, tt(2));
      report("R6", aa(5), 1'b0, 32'h0, 1'b1);     // empties slot 5
      report("R9", aa(18), 1'b1, tt(18), 1'b1);   // fills slot 5
      look("R9", aa(2), 1'b1, tt(2));
      look("R9", aa(18), 1'b1, tt(18));
      look("R9", aa(5), 1'b0, aa(5) + 32'd4);
      report("R9", aa(19), 1'b1, tt(19), 1'b1);   // overwrites slot 2
      look("R9", aa(2), 1'b0, aa(2) + 32'd4);
      look("R9", aa(3), 1'b1, tt(3));
   endtask

   task automatic t_loop();
      int mp = 0;
      int br = 0;
      do_reset();
      for (int pass = 0; pass < 3; pass++) begin
         for (int it = 0; it < 10; it++) begin
            cyc(1'b0, '0, 1'b1, 32'h0000_3000, (it < 9), 32'h0000_2F00);
            br++;
            if (rs_mispredict) mp++;
         end
      end
      chk("R5 R6 loop mispredicts", 32'(mp), 32'd6);
      $display("measured branch penalty = %0.3f cycles/branch (2-cycle refill)",
               2.0 * real'(mp) / real'(br));
   endtask

   initial begin
      t_reset();
      t_insert();
      t_fill();
      t_loop();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule